// File: doc/BRIEF.md
# In-Order Commit Queue

This block is a circular queue of in-flight micro-operations. A front end places operations into it in program order, up to two per cycle, and receives a tag for each one. Execution units finish operations in any order. Each finished operation writes its result and a branch-mispredict flag back through its tag. A read port lets a waiting operation pick up a finished result before that result becomes architectural. At the oldest end, finished entries leave in program order, up to two per cycle. Their destination register and result form the commit stream that updates the program-visible register file.

A commit of an entry that carries the mispredict flag still makes that entry's result permanent. Every entry younger than it is discarded in the same cycle. A small controller with four named states governs allocation:
- **EMPTY**: no entries are held.
- **OPEN**: partly filled.
- **FULL**: all entries are held.
- **RECOVER**: a one-cycle state after a squash, while the front end is redirected.

The transitions are:
- **squash**: from any state to RECOVER.
- **recover-done**: from RECOVER to EMPTY.
- **occupancy**: among EMPTY, OPEN and FULL, chosen from the number of entries after the cycle's allocations and commits.

Top module: `commit_queue`

## Requirements
- R1: After reset the queue holds no entries, `ret_valid` is 0, `squash` is 0, `rd_ready` is 0, and a request for two allocations is accepted.
- R2: Entries are allocated at the tail in program order. Requesting lanes are numbered from lane 0 upward. The first requesting lane gets tag `tail mod 16`, and the next requesting lane gets the following tag.
- R3: An allocation request is accepted as a whole (`alloc_ok`=1) only when the number of free entries, counted before this cycle's commits, is at least the number of lanes requesting. A full queue holds 16 entries. A rejected request changes nothing.
- R4: A completion on a held entry marks it finished and stores its result and mispredict flag. A completion whose tag names an entry that is not held is ignored, and that entry still reads as not ready.
- R5: The read port reports `rd_ready`=1 and the stored result on `rd_data` for a held, finished entry. It updates in the cycle after the completing edge.
- R6: Commits leave only from the head and only when finished. Up to two commit per cycle, and commit stops at the first unfinished entry. `ret_valid` therefore always has the form 00, 01 or 11.
- R7: Commit lane 0 carries the oldest committing entry and lane 1 the next one. Each lane presents that entry's destination register and result.
- R8: When a committing entry carries the mispredict flag, its result commits, `squash` is 1, no younger entry commits, and the queue is empty after that edge.
- R9: In the cycle after a squash, every allocation request is refused. In the cycle after that, allocation resumes at the tag just past the squashing entry.
- R10: Allocation and commit in the same cycle are allowed. A full queue refuses allocation even in a cycle where entries commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 2 | Allocation request, one bit per lane |
| alloc_dst | input | 10 | Destination register per lane, 5 bits each |
| alloc_ok | output | 1 | Request accepted this cycle |
| alloc_tag | output | 8 | Tag given to each lane, 4 bits each |
| cmp_valid | input | 2 | Completion valid per write-back lane |
| cmp_tag | input | 8 | Completion tag per lane |
| cmp_data | input | 64 | Completion result per lane, 32 bits each |
| cmp_mispred | input | 2 | Completion marks a mispredicted branch |
| rd_tag | input | 4 | Operand read tag |
| rd_ready | output | 1 | Tagged entry is held and finished |
| rd_data | output | 32 | Result of the tagged entry |
| ret_valid | output | 2 | Commit valid per lane |
| ret_dst | output | 10 | Committed destination register per lane |
| ret_data | output | 64 | Committed result per lane |
| squash | output | 1 | Younger entries are discarded at this edge |

## Verification
`alloc_ok`, `alloc_tag`, the commit lanes and `squash` are combinational from registered state. The bench therefore samples them one time step after driving inputs at the falling edge, in the same cycle. A completion shows on the read port and becomes eligible to commit only in the cycle after its rising edge. A squash empties the queue at its edge, and the refusal it causes lasts exactly the following cycle. The bench's reference queue advances only at each rising edge, so every expected value is taken from the state that edge produced.

// File: rtl/cq_pkg.sv
package cq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_OPEN    = 2'd1,
        Q_FULL    = 2'd2,
        Q_RECOVER = 2'd3
    } cq_state_e;

endpackage

// File: rtl/cq_ctrl.sv
module cq_ctrl
    import cq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ALLOC_N = 2,
    parameter int RET_N   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ALLOC_N-1:0]           alloc_req,
    input  logic [$clog2(RET_N+1)-1:0]   ret_cnt,
    input  logic                         squash,
    output logic                         alloc_ok,
    output logic [ALLOC_N-1:0]           alloc_we,
    output logic [ALLOC_N*$clog2(DEPTH)-1:0] alloc_idx,
    output logic [$clog2(DEPTH)-1:0]     head_idx,
    output logic [$clog2(DEPTH):0]       occ
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int PTR_W  = IDX_W + 1;
    localparam int RCNT_W = $clog2(RET_N + 1);

    cq_state_e state_q, state_d;
    logic [PTR_W-1:0] head_q, tail_q, head_d, tail_d;
    logic [PTR_W-1:0] nreq, free_cnt, occ_d;

    // count requesting lanes
    always_comb begin
        nreq = '0;
        for (int i = 0; i < ALLOC_N; i++) begin
            nreq = nreq + PTR_W'(alloc_req[i]);
        end
    end

    assign occ      = tail_q - head_q;
    assign free_cnt = PTR_W'(DEPTH) - occ;
    assign head_idx = head_q[IDX_W-1:0];

    // output process: acceptance per state
    always_comb begin
        alloc_ok = 1'b0;
        unique case (state_q)
            Q_EMPTY:   alloc_ok = !squash;
            Q_OPEN:    alloc_ok = !squash && (nreq <= free_cnt);
            Q_FULL:    alloc_ok = !squash && (nreq == '0);
            Q_RECOVER: alloc_ok = 1'b0;
            default:   alloc_ok = 1'b0;
        endcase
    end

    // lane tag assignment in program order
    always_comb begin
        logic [IDX_W-1:0] off;
        off = '0;
        for (int i = 0; i < ALLOC_N; i++) begin
            alloc_idx[i*IDX_W +: IDX_W] = tail_q[IDX_W-1:0] + off;
            alloc_we[i] = alloc_ok && alloc_req[i];
            off = off + IDX_W'(alloc_req[i]);
        end
    end

    // pointer and next-state computation
    always_comb begin
        head_d = head_q + PTR_W'(ret_cnt);
        if (squash) begin
            tail_d = head_d;
        end else if (alloc_ok) begin
            tail_d = tail_q + nreq;
        end else begin
            tail_d = tail_q;
        end
        occ_d = tail_d - head_d;
        if (squash) begin
            state_d = Q_RECOVER;
        end else if (occ_d == '0) begin
            state_d = Q_EMPTY;
        end else if (occ_d == PTR_W'(DEPTH)) begin
            state_d = Q_FULL;
        end else begin
            state_d = Q_OPEN;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
        end
    end

    logic unused_rcnt;
    assign unused_rcnt = ^{RCNT_W{1'b0}};

endmodule

// File: rtl/cq_store.sv
module cq_store #(
    parameter int DEPTH   = 16,
    parameter int DATA_W  = 32,
    parameter int AREG_W  = 5,
    parameter int ALLOC_N = 2,
    parameter int CMP_N   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ALLOC_N-1:0]                 alloc_we,
    input  logic [ALLOC_N*$clog2(DEPTH)-1:0]   alloc_idx,
    input  logic [ALLOC_N*AREG_W-1:0]          alloc_dst,
    input  logic [CMP_N-1:0]                   cmp_valid,
    input  logic [CMP_N*$clog2(DEPTH)-1:0]     cmp_tag,
    input  logic [CMP_N*DATA_W-1:0]            cmp_data,
    input  logic [CMP_N-1:0]                   cmp_mispred,
    input  logic [DEPTH-1:0]                   ret_mask,
    input  logic                               squash,
    output logic [DEPTH-1:0]                   ent_valid,
    output logic [DEPTH-1:0]                   ent_done,
    output logic [DEPTH-1:0]                   ent_mp,
    output logic [AREG_W-1:0]                  ent_dst  [DEPTH],
    output logic [DATA_W-1:0]                  ent_data [DEPTH]
);
    localparam int IDX_W = $clog2(DEPTH);

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic              a_hit, c_hit, c_mp;
        logic [AREG_W-1:0] a_dst;
        logic [DATA_W-1:0] c_data;

        always_comb begin
            a_hit = 1'b0;
            a_dst = '0;
            for (int i = 0; i < ALLOC_N; i++) begin
                if (alloc_we[i] && alloc_idx[i*IDX_W +: IDX_W] == IDX_W'(e)) begin
                    a_hit = 1'b1;
                    a_dst = alloc_dst[i*AREG_W +: AREG_W];
                end
            end
            c_hit  = 1'b0;
            c_mp   = 1'b0;
            c_data = '0;
            for (int j = 0; j < CMP_N; j++) begin
                if (cmp_valid[j] && cmp_tag[j*IDX_W +: IDX_W] == IDX_W'(e)) begin
                    c_hit  = 1'b1;
                    c_mp   = cmp_mispred[j];
                    c_data = cmp_data[j*DATA_W +: DATA_W];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[e] <= 1'b0;
                ent_done[e]  <= 1'b0;
                ent_mp[e]    <= 1'b0;
                ent_dst[e]   <= '0;
                ent_data[e]  <= '0;
            end else begin
                if (squash || ret_mask[e]) begin
                    ent_valid[e] <= 1'b0;
                end else if (a_hit) begin
                    ent_valid[e] <= 1'b1;
                    ent_done[e]  <= 1'b0;
                    ent_mp[e]    <= 1'b0;
                    ent_dst[e]   <= a_dst;
                end
                if (c_hit && ent_valid[e] && !a_hit) begin
                    ent_done[e] <= 1'b1;
                    ent_mp[e]   <= c_mp;
                    ent_data[e] <= c_data;
                end
            end
        end
    end

endmodule

// File: rtl/cq_retire.sv
module cq_retire #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int AREG_W = 5,
    parameter int RET_N  = 2
) (
    input  logic [$clog2(DEPTH)-1:0]     head_idx,
    input  logic [DEPTH-1:0]             ent_valid,
    input  logic [DEPTH-1:0]             ent_done,
    input  logic [DEPTH-1:0]             ent_mp,
    input  logic [AREG_W-1:0]            ent_dst  [DEPTH],
    input  logic [DATA_W-1:0]            ent_data [DEPTH],
    output logic [RET_N-1:0]             ret_valid,
    output logic [RET_N*AREG_W-1:0]      ret_dst,
    output logic [RET_N*DATA_W-1:0]      ret_data,
    output logic [$clog2(RET_N+1)-1:0]   ret_cnt,
    output logic [DEPTH-1:0]             ret_mask,
    output logic                         squash
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int RCNT_W = $clog2(RET_N + 1);

    always_comb begin
        logic             go;
        logic [IDX_W-1:0] idx;
        ret_valid = '0;
        ret_dst   = '0;
        ret_data  = '0;
        ret_cnt   = '0;
        ret_mask  = '0;
        squash    = 1'b0;
        go        = 1'b1;
        for (int k = 0; k < RET_N; k++) begin
            idx = head_idx + IDX_W'(k);
            if (go && ent_valid[idx] && ent_done[idx]) begin
                ret_valid[k]                  = 1'b1;
                ret_dst[k*AREG_W +: AREG_W]   = ent_dst[idx];
                ret_data[k*DATA_W +: DATA_W]  = ent_data[idx];
                ret_mask[idx]                 = 1'b1;
                ret_cnt                       = RCNT_W'(k + 1);
                if (ent_mp[idx]) begin
                    squash = 1'b1;
                    go     = 1'b0;
                end
            end else begin
                go = 1'b0;
            end
        end
    end

endmodule

// File: rtl/commit_queue.sv
module commit_queue #(
    parameter int DEPTH   = 16,
    parameter int DATA_W  = 32,
    parameter int AREG_W  = 5,
    parameter int ALLOC_N = 2,
    parameter int CMP_N   = 2,
    parameter int RET_N   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ALLOC_N-1:0]               alloc_req,
    input  logic [ALLOC_N*AREG_W-1:0]        alloc_dst,
    output logic                             alloc_ok,
    output logic [ALLOC_N*$clog2(DEPTH)-1:0] alloc_tag,
    input  logic [CMP_N-1:0]                 cmp_valid,
    input  logic [CMP_N*$clog2(DEPTH)-1:0]   cmp_tag,
    input  logic [CMP_N*DATA_W-1:0]          cmp_data,
    input  logic [CMP_N-1:0]                 cmp_mispred,
    input  logic [$clog2(DEPTH)-1:0]         rd_tag,
    output logic                             rd_ready,
    output logic [DATA_W-1:0]                rd_data,
    output logic [RET_N-1:0]                 ret_valid,
    output logic [RET_N*AREG_W-1:0]          ret_dst,
    output logic [RET_N*DATA_W-1:0]          ret_data,
    output logic                             squash
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int PTR_W  = IDX_W + 1;
    localparam int RCNT_W = $clog2(RET_N + 1);

    logic [ALLOC_N-1:0]  alloc_we;
    logic [IDX_W-1:0]    head_idx;
    logic [PTR_W-1:0]    occ;
    logic [RCNT_W-1:0]   ret_cnt;
    logic [DEPTH-1:0]    ret_mask;
    logic [DEPTH-1:0]    ent_valid, ent_done, ent_mp;
    logic [AREG_W-1:0]   ent_dst  [DEPTH];
    logic [DATA_W-1:0]   ent_data [DEPTH];

    cq_ctrl #(.DEPTH(DEPTH), .ALLOC_N(ALLOC_N), .RET_N(RET_N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_req(alloc_req),
        .ret_cnt  (ret_cnt),
        .squash   (squash),
        .alloc_ok (alloc_ok),
        .alloc_we (alloc_we),
        .alloc_idx(alloc_tag),
        .head_idx (head_idx),
        .occ      (occ)
    );

    cq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W),
               .ALLOC_N(ALLOC_N), .CMP_N(CMP_N)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_we   (alloc_we),
        .alloc_idx  (alloc_tag),
        .alloc_dst  (alloc_dst),
        .cmp_valid  (cmp_valid),
        .cmp_tag    (cmp_tag),
        .cmp_data   (cmp_data),
        .cmp_mispred(cmp_mispred),
        .ret_mask   (ret_mask),
        .squash     (squash),
        .ent_valid  (ent_valid),
        .ent_done   (ent_done),
        .ent_mp     (ent_mp),
        .ent_dst    (ent_dst),
        .ent_data   (ent_data)
    );

    cq_retire #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W),
                .RET_N(RET_N)) u_retire (
        .head_idx (head_idx),
        .ent_valid(ent_valid),
        .ent_done (ent_done),
        .ent_mp   (ent_mp),
        .ent_dst  (ent_dst),
        .ent_data (ent_data),
        .ret_valid(ret_valid),
        .ret_dst  (ret_dst),
        .ret_data (ret_data),
        .ret_cnt  (ret_cnt),
        .ret_mask (ret_mask),
        .squash   (squash)
    );

    // operand bypass read
    assign rd_ready = ent_valid[rd_tag] && ent_done[rd_tag];
    assign rd_data  = ent_data[rd_tag];

endmodule

// File: rtl/commit_queue_chk.sv
module commit_queue_chk #(
    parameter int DEPTH   = 16,
    parameter int ALLOC_N = 2,
    parameter int RET_N   = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ALLOC_N-1:0]      alloc_req,
    input logic                    alloc_ok,
    input logic [RET_N-1:0]        ret_valid,
    input logic                    squash,
    input logic [$clog2(DEPTH):0]  occ
);
    localparam int PTR_W = $clog2(DEPTH) + 1;

    // R6
    ret_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret_valid + RET_N'(1)) & ret_valid) == '0);

    // R3
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PTR_W'(DEPTH));

    // R3
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == PTR_W'(DEPTH) && alloc_req != '0) |-> !alloc_ok);

    // R8
    squash_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> ret_valid[0]);

    // R8
    squash_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (occ == '0));

    // R9
    recover_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !alloc_ok);

endmodule

bind commit_queue commit_queue_chk #(
    .DEPTH(DEPTH), .ALLOC_N(ALLOC_N), .RET_N(RET_N)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_req(alloc_req),
    .alloc_ok (alloc_ok),
    .ret_valid(ret_valid),
    .squash   (squash),
    .occ      (occ)
);

// File: tb/test_commit_queue.sv
`timescale 1ns/1ps
module test_commit_queue;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  a_req;
    logic [9:0]  a_dst;
    logic        alloc_ok;
    logic [7:0]  alloc_tag;
    logic [1:0]  c_valid;
    logic [7:0]  c_tag;
    logic [63:0] c_data;
    logic [1:0]  c_mp;
    logic [3:0]  rd_tag;
    logic        rd_ready;
    logic [31:0] rd_data;
    logic [1:0]  ret_valid;
    logic [9:0]  ret_dst;
    logic [63:0] ret_data;
    logic        squash;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit          m_v [D];
    bit          m_d [D];
    bit          m_mp[D];
    logic [4:0]  m_dst [D];
    logic [31:0] m_data[D];
    int          mh = 0, mt = 0;
    bit          m_rec = 0;

    always #10 clk = ~clk;

    commit_queue i_commit_queue (
        .clk(clk), .rst_n(rst_n), .alloc_req(a_req), .alloc_dst(a_dst),
        .alloc_ok(alloc_ok), .alloc_tag(alloc_tag), .cmp_valid(c_valid),
        .cmp_tag(c_tag), .cmp_data(c_data), .cmp_mispred(c_mp),
        .rd_tag(rd_tag), .rd_ready(rd_ready), .rd_data(rd_data),
        .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_data(ret_data),
        .squash(squash)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive inputs after a falling edge, then let outputs settle
    task automatic drive(input logic [1:0] req, input logic [1:0] cv,
                         input logic [3:0] t0, input logic [3:0] t1,
                         input logic [1:0] mp, input logic [3:0] rt);
        a_req   = req;
        a_dst   = 10'($urandom);
        c_valid = cv;
        c_tag   = {t1, t0};
        c_data  = {32'($urandom), 32'($urandom)};
        c_mp    = mp;
        rd_tag  = rt;
        #1;
    endtask

    function automatic bit exp_ok();
        int nreq, occ, rc;
        bit go, sq;
        nreq = int'(a_req[0]) + int'(a_req[1]);
        occ = mt - mh;
        go = 1; sq = 0;
        for (int k = 0; k < 2; k++) begin
            rc = (mh + k) % D;
            if (go && m_v[rc] && m_d[rc]) begin
                if (m_mp[rc]) begin sq = 1; go = 0; end
            end else go = 0;
        end
        return !m_rec && !sq && (nreq <= D - occ);
    endfunction

    // compare all outputs against the reference queue, then advance one edge
    task automatic step();
        bit go, sq, ok;
        int rcnt, idx, occ, nreq, ti;
        logic [1:0] ev;
        go = 1; sq = 0; rcnt = 0; ev = 2'b00;
        occ = mt - mh;
        nreq = int'(a_req[0]) + int'(a_req[1]);
        for (int k = 0; k < 2; k++) begin
            idx = (mh + k) % D;
            if (go && m_v[idx] && m_d[idx]) begin
                ev[k] = 1'b1;
                rcnt = k + 1;
                chk("R7", "ret_dst", 64'(ret_dst[k*5 +: 5]), 64'(m_dst[idx]));
                chk("R7", "ret_data", 64'(ret_data[k*32 +: 32]), 64'(m_data[idx]));
                if (m_mp[idx]) begin sq = 1; go = 0; end
            end else go = 0;
        end
        chk("R6", "ret_valid", 64'(ret_valid), 64'(ev));
        chk("R8", "squash", 64'(squash), 64'(sq));
        ok = !m_rec && !sq && (nreq <= D - occ);
        chk(m_rec ? "R9" : "R3", "alloc_ok", 64'(alloc_ok), 64'(ok));
        if (ok) begin
            if (a_req[0]) chk("R2", "tag0", 64'(alloc_tag[3:0]), 64'(mt % D));
            if (a_req[1]) chk("R2", "tag1", 64'(alloc_tag[7:4]),
                              64'((mt + int'(a_req[0])) % D));
        end
        chk("R4", "rd_ready", 64'(rd_ready), 64'(m_v[rd_tag] && m_d[rd_tag]));
        if (m_v[rd_tag] && m_d[rd_tag])
            chk("R5", "rd_data", 64'(rd_data), 64'(m_data[rd_tag]));
        @(posedge clk);
        for (int l = 0; l < 2; l++) begin
            ti = int'(c_tag[l*4 +: 4]);
            if (c_valid[l] && m_v[ti]) begin
                m_d[ti] = 1; m_mp[ti] = c_mp[l]; m_data[ti] = c_data[l*32 +: 32];
            end
        end
        for (int k = 0; k < rcnt; k++) m_v[(mh + k) % D] = 0;
        mh = mh + rcnt;
        if (sq) begin
            for (int e = 0; e < D; e++) m_v[e] = 0;
            mt = mh;
        end else if (ok) begin
            for (int l = 0; l < 2; l++) begin
                if (a_req[l]) begin
                    m_v[mt % D] = 1; m_d[mt % D] = 0; m_mp[mt % D] = 0;
                    m_dst[mt % D] = a_dst[l*5 +: 5];
                    mt++;
                end
            end
        end
        m_rec = sq;
        @(negedge clk);
    endtask

    initial begin
        logic [3:0] t0, t1;
        logic [1:0] cv, mp;
        void'($urandom(32'h5eed_0042));
        for (int e = 0; e < D; e++) begin
            m_v[e] = 0; m_d[e] = 0; m_mp[e] = 0; m_dst[e] = '0; m_data[e] = '0;
        end
        rst_n = 1'b0;
        drive(2'b00, 2'b00, 4'd0, 4'd0, 2'b00, 4'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        drive(2'b11, 2'b00, 4'd0, 4'd0, 2'b00, 4'd0);
        chk("R1", "ret_valid", 64'(ret_valid), 64'd0);
        chk("R1", "squash", 64'(squash), 64'd0);
        chk("R1", "rd_ready", 64'(rd_ready), 64'd0);
        chk("R1", "alloc_ok", 64'(alloc_ok), 64'd1);
        step();
        // fill to 16
        for (int i = 0; i < 7; i++) begin
            drive(2'b11, 2'b00, 4'd0, 4'd0, 2'b00, 4'(i));
            step();
        end
        drive(2'b01, 2'b00, 4'd0, 4'd0, 2'b00, 4'd0);
        chk("R3", "full alloc_ok", 64'(alloc_ok), 64'd0);
        step();
        // out-of-order completion: entry 1 first
        drive(2'b00, 2'b01, 4'd1, 4'd0, 2'b00, 4'd1);
        step();
        drive(2'b00, 2'b01, 4'd0, 4'd0, 2'b00, 4'd1);
        chk("R6", "no retire past head", 64'(ret_valid), 64'd0);
        chk("R5", "rd_ready early result", 64'(rd_ready), 64'd1);
        step();
        // full queue commits two while a request arrives
        drive(2'b01, 2'b00, 4'd0, 4'd0, 2'b00, 4'd0);
        chk("R6", "two commits", 64'(ret_valid), 64'd3);
        chk("R10", "full refuses during commit", 64'(alloc_ok), 64'd0);
        step();
        // mispredict on tag 3, tag 2 plain
        drive(2'b00, 2'b11, 4'd2, 4'd3, 2'b10, 4'd2);
        step();
        drive(2'b00, 2'b00, 4'd0, 4'd0, 2'b00, 4'd5);
        chk("R8", "squash", 64'(squash), 64'd1);
        chk("R8", "commit through mispredict", 64'(ret_valid), 64'd3);
        step();
        drive(2'b11, 2'b00, 4'd0, 4'd0, 2'b00, 4'd5);
        chk("R9", "recover refuses", 64'(alloc_ok), 64'd0);
        chk("R8", "younger discarded", 64'(rd_ready), 64'd0);
        step();
        drive(2'b11, 2'b00, 4'd0, 4'd0, 2'b00, 4'd0);
        chk("R9", "alloc resumes", 64'(alloc_ok), 64'd1);
        chk("R9", "resume tag", 64'(alloc_tag), 64'h54);
        step();
        // R4 completion to a free entry is ignored
        drive(2'b00, 2'b01, 4'd9, 4'd0, 2'b00, 4'd9);
        step();
        drive(2'b00, 2'b00, 4'd0, 4'd0, 2'b00, 4'd9);
        chk("R4", "ignored completion", 64'(rd_ready), 64'd0);
        step();

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            cv = 2'b00; mp = 2'b00;
            t0 = 4'($urandom); t1 = 4'($urandom);
            if (m_v[t0] && !m_d[t0]) cv[0] = ($urandom % 4) != 0;
            else if (!m_v[t0]) cv[0] = ($urandom % 8) == 0;
            if (m_v[t1] && !m_d[t1]) cv[1] = ($urandom % 4) != 0;
            else if (!m_v[t1]) cv[1] = ($urandom % 8) == 0;
            if (t1 == t0) cv[1] = 1'b0;
            mp[0] = ($urandom % 16) == 0;
            mp[1] = ($urandom % 16) == 0;
            drive(2'($urandom), cv, t0, t1, mp, 4'($urandom));
            step();
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule